// File: doc/BRIEF.md
# Latched Parallel-to-Serial Input Expander

This block turns eight parallel input lines into a serial bit stream for a host that has few pins. A rising edge on the capture strobe stores the eight lines in a holding register. Holding the load select low then copies that register into an eight-stage shift register. After the select is released, each rising edge of the shift strobe moves the register one stage towards the output. The last stage appears at the serial output, and the serial input enters the first stage. Wiring the serial output of one unit to the serial input of the next builds a longer chain. A drive-enable lets several units share one return line.

All control and data inputs are asynchronous to the system clock. Each one passes through a synchronizer of `SYNC_STAGES` flops, and edges are detected after that. Every action therefore takes effect on the third system-clock edge after the input is first sampled, with the default of two stages. The tri-state pad is outside the block. The block gives the pad its data and its enable, and parks the data line low while the enable is off.

Top module: `pso_latched_shifter`

## Requirements
- R1: After reset the holding register and the shift register are all zero, and `ser_out` is 0.
- R2: On a rising edge of `latch_clk`, the holding register captures `par_in`. Bit 0 is line A, which maps to the first stage. Bit 7 is line H, which maps to the last stage.
- R3: While `latch_clk` has no rising edge, changes on `par_in` do not alter the holding register.
- R4: On every system clock while `shift_load_n` is low, the shift register is loaded from the holding register. A shift edge arriving during that time has no effect.
- R5: While `shift_load_n` is high, each rising edge of `shift_clk` shifts the register by one stage. Stage 7 goes to stage 8 position out, `ser_in` enters stage 0, and stage 7 is shown at `ser_out`. A byte therefore leaves with bit 7 first.
- R6: A falling edge of `shift_clk` leaves the shift register unchanged.
- R7: `ser_oe` is high exactly while `out_en_n` is low. While `ser_oe` is low, `ser_out` is 0 and the stored contents are kept.
- R8: With `SYNC_STAGES`=2, a change on any input is acted upon at the third rising system-clock edge after the first edge that samples it.
- R9: With two units chained, 16 shift edges deliver the downstream byte first and then the upstream byte, each with bit 7 first.
- R10: If a load and a capture fall on the same system clock, the shift register receives the holding value from before that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latch_clk | input | 1 | Capture strobe; a rising edge stores `par_in` |
| shift_load_n | input | 1 | Low: load from the holding register; high: shift mode |
| shift_clk | input | 1 | Shift strobe; a rising edge advances the register |
| ser_in | input | 1 | Serial input into stage 0 (chain input) |
| out_en_n | input | 1 | Active-low serial output enable |
| par_in | input | WIDTH | Parallel input lines, A in bit 0 |
| ser_out | output | 1 | Last stage when enabled, else 0 |
| ser_oe | output | 1 | Drive-enable for the external serial pad |

## Verification
The hardest case to reach is a load and a capture that resolve on the same system-clock edge. That only happens when the load select stays low for exactly one system clock, in the same cycle the capture strobe rises. The stimulus moves both inputs on the same falling clock edge and releases the select one cycle later. The bench then shifts the register out and expects the old holding byte, and after a second load it expects the new one. The synchronizer latency is pinned by raising the shift strobe and sampling the output on each of the following three cycles.

// File: rtl/pso_pkg.sv
package pso_pkg;

    // Operation applied to the shift register in one system clock
    typedef enum logic [1:0] {
        SR_KEEP  = 2'd0,
        SR_LOAD  = 2'd1,
        SR_SHIFT = 2'd2
    } sr_op_e;

    // Positions of the control lines inside the synchronized bus
    localparam int BIT_LC = 0;
    localparam int BIT_SC = 1;
    localparam int BIT_SL = 2;
    localparam int BIT_SI = 3;
    localparam int CTRL_W = 4;

endpackage

// File: rtl/pso_sync.sv
module pso_sync #(
    parameter int          W       = 12,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[g] <= RST_VAL;
                end else begin
                    stg_q[g] <= stg_d[g];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pso_rise_det.sv
module pso_rise_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);

    logic [W-1:0] prev_d;
    logic [W-1:0] prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    generate
        for (genvar g = 0; g < W; g++) begin : g_edge
            assign rise[g] = lvl[g] & ~prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/pso_shift_core.sv
module pso_shift_core
    import pso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [WIDTH-1:0] cap_data,
    input  logic             load_lvl,
    input  logic             shift_en,
    input  logic             shift_bit,
    output logic [WIDTH-1:0] hold_q,
    output logic [WIDTH-1:0] sr_q
);

    typedef struct packed {
        logic [WIDTH-1:0] hold;
        logic [WIDTH-1:0] sr;
    } core_t;

    core_t  st_d;
    core_t  st_q;
    sr_op_e op;

    always_comb begin
        st_d = st_q;
        if (load_lvl) begin
            op = SR_LOAD;
        end else if (shift_en) begin
            op = SR_SHIFT;
        end else begin
            op = SR_KEEP;
        end

        unique case (op)
            SR_LOAD:  st_d.sr = st_q.hold;
            SR_SHIFT: st_d.sr = {st_q.sr[WIDTH-2:0], shift_bit};
            default:  st_d.sr = st_q.sr;
        endcase

        if (cap_en) begin
            st_d.hold = cap_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_q = st_q.hold;
    assign sr_q   = st_q.sr;

endmodule

// File: rtl/pso_latched_shifter.sv
module pso_latched_shifter
    import pso_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_clk,
    input  logic             shift_load_n,
    input  logic             shift_clk,
    input  logic             ser_in,
    input  logic             out_en_n,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out,
    output logic             ser_oe
);

    localparam int               BUS_W   = WIDTH + CTRL_W;
    localparam logic [BUS_W-1:0] BUS_RST = BUS_W'(1) << BIT_SL;

    logic [BUS_W-1:0] bus_raw;
    logic [BUS_W-1:0] bus_s;
    logic [1:0]       rise;
    logic             lc_rise;
    logic             sc_rise;
    logic             load_lvl;
    logic             si_s;
    logic [WIDTH-1:0] hold_q;
    logic [WIDTH-1:0] sr_q;

    assign bus_raw = {par_in, ser_in, shift_load_n, shift_clk, latch_clk};

    pso_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_RST)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_raw),
        .q     (bus_s)
    );

    pso_rise_det #(
        .W (2)
    ) i_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({bus_s[BIT_SC], bus_s[BIT_LC]}),
        .rise  (rise)
    );

    assign lc_rise  = rise[0];
    assign sc_rise  = rise[1];
    assign load_lvl = ~bus_s[BIT_SL];
    assign si_s     = bus_s[BIT_SI];

    pso_shift_core #(
        .WIDTH (WIDTH)
    ) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (lc_rise),
        .cap_data  (bus_s[BUS_W-1:CTRL_W]),
        .load_lvl  (load_lvl),
        .shift_en  (sc_rise),
        .shift_bit (si_s),
        .hold_q    (hold_q),
        .sr_q      (sr_q)
    );

    assign ser_oe  = ~out_en_n;
    assign ser_out = ser_oe & sr_q[WIDTH-1];

endmodule

// File: rtl/pso_latched_shifter_chk.sv
module pso_latched_shifter_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lc_rise,
    input logic             sc_rise,
    input logic             load_lvl,
    input logic             si_s,
    input logic [WIDTH-1:0] hold_q,
    input logic [WIDTH-1:0] sr_q,
    input logic             ser_oe,
    input logic             ser_out
);

    // R3
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lc_rise |=> $stable(hold_q));

    // R10
    load_old_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_lvl |=> (sr_q == $past(hold_q)));

    // R5
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_lvl && sc_rise) |=>
            (sr_q == {$past(sr_q[WIDTH-2:0]), $past(si_s)}));

    // R6
    sr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_lvl && !sc_rise) |=> $stable(sr_q));

    // R7
    park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_oe |-> !ser_out);

endmodule

bind pso_latched_shifter pso_latched_shifter_chk #(.WIDTH(WIDTH)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lc_rise  (lc_rise),
    .sc_rise  (sc_rise),
    .load_lvl (load_lvl),
    .si_s     (si_s),
    .hold_q   (hold_q),
    .sr_q     (sr_q),
    .ser_oe   (ser_oe),
    .ser_out  (ser_out)
);

// File: tb/test_pso_latched_shifter.sv
module test_pso_latched_shifter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lc = 1'b0;
    logic       sl = 1'b1;
    logic       sc = 1'b0;
    logic       si0 = 1'b1;
    logic [1:0] oen = 2'b00;
    logic [7:0] par0 = 8'h00;
    logic [7:0] par1 = 8'h00;
    logic       so0, so1, oe0, oe1;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    pso_latched_shifter i_pso_latched_shifter (
        .clk(clk), .rst_n(rst_n), .latch_clk(lc), .shift_load_n(sl),
        .shift_clk(sc), .ser_in(si0), .out_en_n(oen[0]), .par_in(par0),
        .ser_out(so0), .ser_oe(oe0)
    );

    pso_latched_shifter i_down (
        .clk(clk), .rst_n(rst_n), .latch_clk(lc), .shift_load_n(sl),
        .shift_clk(sc), .ser_in(so0), .out_en_n(oen[1]), .par_in(par1),
        .ser_out(so1), .ser_oe(oe1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: input histories (index 0 newest) and state per unit
    logic       h_lc [2][$];
    logic       h_sc [2][$];
    logic       h_sl [2][$];
    logic       h_si [2][$];
    logic [7:0] h_par [2][$];
    logic [7:0] m_hold [2];
    logic [7:0] m_sr [2];
    logic       m_out [2];
    logic       m_oe [2];

    always @(posedge clk) begin
        logic cur_si [2];
        logic [7:0] cur_par [2];
        cur_par[0] = par0;
        cur_par[1] = par1;
        if (!rst_n) begin
            for (int u = 0; u < 2; u++) begin
                h_lc[u] = '{1'b0, 1'b0, 1'b0};
                h_sc[u] = '{1'b0, 1'b0, 1'b0};
                h_sl[u] = '{1'b1, 1'b1, 1'b1};
                h_si[u] = '{1'b0, 1'b0, 1'b0};
                h_par[u] = '{8'h00, 8'h00, 8'h00};
                m_hold[u] = 8'h00;
                m_sr[u] = 8'h00;
            end
        end else begin
            cur_si[0] = si0;
            cur_si[1] = (!oen[0]) ? m_sr[0][7] : 1'b0;
            for (int u = 0; u < 2; u++) begin
                logic [7:0] old_hold;
                old_hold = m_hold[u];
                if (h_lc[u][1] && !h_lc[u][2]) m_hold[u] = h_par[u][1];
                if (!h_sl[u][1]) m_sr[u] = old_hold;
                else if (h_sc[u][1] && !h_sc[u][2]) m_sr[u] = {m_sr[u][6:0], h_si[u][1]};
                h_lc[u].push_front(lc);   void'(h_lc[u].pop_back());
                h_sc[u].push_front(sc);   void'(h_sc[u].pop_back());
                h_sl[u].push_front(sl);   void'(h_sl[u].pop_back());
                h_si[u].push_front(cur_si[u]); void'(h_si[u].pop_back());
                h_par[u].push_front(cur_par[u]); void'(h_par[u].pop_back());
            end
        end
        #5;
        for (int u = 0; u < 2; u++) begin
            m_oe[u]  = !oen[u];
            m_out[u] = m_oe[u] & m_sr[u][7];
        end
        chk({cur_req, " model unit0"}, {30'd0, so0, oe0}, {30'd0, m_out[0], m_oe[0]});
        chk({cur_req, " model unit1"}, {30'd0, so1, oe1}, {30'd0, m_out[1], m_oe[1]});
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_latch();
        lc = 1'b1; wait_n(4);
        lc = 1'b0; wait_n(4);
    endtask

    task automatic do_load();
        sl = 1'b0; wait_n(4);
        sl = 1'b1; wait_n(4);
    endtask

    task automatic shift_pulse();
        sc = 1'b1; wait_n(4);
        sc = 1'b0; wait_n(4);
    endtask

    task automatic read_bits(input int n, output logic [31:0] v);
        v = '0;
        for (int b = 0; b < n; b++) begin
            v = {v[30:0], so1};
            shift_pulse();
        end
    endtask

    initial begin
        logic [31:0] v;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(4);

        cur_req = "R1";
        chk("R1 reset ser_out", {31'd0, so1}, 32'd0);
        chk("R1 reset oe", {31'd0, oe1}, 32'd1);
        do_load();
        read_bits(8, v);
        chk("R1 cleared register", v, 32'h00);

        cur_req = "R9";
        par0 = 8'h3C; par1 = 8'hA5;
        do_latch();
        do_load();
        read_bits(16, v);
        chk("R9 chained 16 bits (R2 order)", v, 32'hA53C);

        cur_req = "R5";
        read_bits(8, v);
        chk("R5 serial input fills chain", v, 32'hFF);

        cur_req = "R3";
        par0 = 8'h00; par1 = 8'h0F;
        wait_n(6);
        do_load();
        read_bits(8, v);
        chk("R3 hold unchanged without capture edge", v, 32'hA5);

        cur_req = "R4";
        sl = 1'b0; wait_n(4);
        shift_pulse();
        sl = 1'b1; wait_n(4);
        read_bits(8, v);
        chk("R4 shift ignored during load", v, 32'hA5);

        cur_req = "R8";
        par1 = 8'h40;
        do_latch();
        do_load();
        chk("R8 start bit", {31'd0, so1}, 32'd0);
        sc = 1'b1;
        wait_n(1);
        chk("R8 no change after 1 cycle", {31'd0, so1}, 32'd0);
        wait_n(1);
        chk("R8 no change after 2 cycles", {31'd0, so1}, 32'd0);
        wait_n(1);
        chk("R8 shifted at third edge", {31'd0, so1}, 32'd1);
        wait_n(4);
        cur_req = "R6";
        sc = 1'b0;
        wait_n(6);
        chk("R6 falling edge ignored", {31'd0, so1}, 32'd1);

        cur_req = "R7";
        oen[1] = 1'b1;
        wait_n(2);
        chk("R7 oe off", {31'd0, oe1}, 32'd0);
        chk("R7 output parked low", {31'd0, so1}, 32'd0);
        wait_n(4);
        oen[1] = 1'b0;
        wait_n(2);
        chk("R7 contents kept", {31'd0, so1}, 32'd1);

        cur_req = "R10";
        do_load();
        par1 = 8'h81;
        wait_n(4);
        sl = 1'b0; lc = 1'b1;
        wait_n(1);
        sl = 1'b1;
        wait_n(4);
        lc = 1'b0;
        wait_n(4);
        read_bits(8, v);
        chk("R10 load takes old hold", v, 32'h40);
        do_load();
        read_bits(8, v);
        chk("R10 new hold after next load", v, 32'h81);

        wait_n(4);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule